// File: doc/BRIEF.md
# Unsigned Subtractor with Sign-Magnitude Result

This block subtracts one unsigned operand from another without any clock. It forms the difference by adding the minuend to the two's complement of the subtrahend: every subtrahend bit is inverted and the adder's carry-in is tied high. When the end carry of that addition is set, the minuend is at least as large as the subtrahend, and the raw sum is already the answer. When the end carry is clear, the raw sum is the difference offset by 2^n. It is complemented and incremented once more to recover the magnitude, and a negative flag is raised.

The result therefore leaves the block in sign-magnitude form: an n-bit magnitude plus a separate sign. The raw end carry is also brought out so that the comparison can be observed on its own. Both adders use carry lookahead within fixed-size groups, and the groups are chained by ripple. The block is purely combinational, so no stream handshake applies.

Top module: `usub_signmag`

## Requirements
- R1: When the minuend is greater than the subtrahend, `mag_o` equals minuend minus subtrahend and `neg_o` is 0.
- R2: When the minuend is less than the subtrahend, `mag_o` equals subtrahend minus minuend and `neg_o` is 1.
- R3: When the two operands are equal, including both zero, `mag_o` is 0 and `neg_o` is 0.
- R4: `carry_o` is 1 exactly when the minuend is greater than or equal to the subtrahend.
- R5: `neg_o` is always the inverse of `carry_o`.
- R6: A zero subtrahend gives `mag_o` equal to the minuend with `carry_o` at 1, because the two's complement of zero is zero.
- R7: With the default width of 7, 1010100 minus 1000011 gives magnitude 0010001 with `carry_o` 1. The swapped operands give magnitude 0010001 with `neg_o` 1 and `carry_o` 0.
- R8: The magnitude always fits in n bits. Minuend 0 with the all-ones subtrahend gives the all-ones magnitude, negative. The all-ones minuend with subtrahend 0 gives the all-ones magnitude, positive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| minuend_i | input | WIDTH | Unsigned value to subtract from |
| subtrahend_i | input | WIDTH | Unsigned value that is subtracted |
| mag_o | output | WIDTH | Absolute value of the difference |
| neg_o | output | 1 | Set when the true difference is below zero |
| carry_o | output | 1 | End carry of the complement-add, brought out for debug |

## Verification
The main function is swept over every pair of 7-bit operands. This exercises all three orderings (greater, equal, less) and the carry propagation through every lookahead group and every group boundary. Directed cases add the zero-subtrahend case, which tests whether the two's complement of zero really contributes nothing. They also add both all-ones extremes, which show whether the re-complement path keeps the full n-bit magnitude. Finally, the worked example pair, in both operand orders, confirms that the same magnitude appears with opposite sign and opposite carry.

// File: rtl/usub_pkg.sv
package usub_pkg;
  localparam int unsigned DEF_WIDTH = 7;
  localparam int unsigned DEF_GROUP = 4;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/usub_lookahead_group.sv
module usub_lookahead_group #(
  parameter int unsigned GROUP = 4
) (
  input  logic [GROUP-1:0] prop_i,
  input  logic [GROUP-1:0] gen_i,
  input  logic             cin_i,
  output logic [GROUP:0]   carry_o
);
  // Each carry is formed as a flat OR of generate terms gated by the
  // propagates above them, plus the carry-in gated by all propagates.
  always_comb begin
    carry_o[0] = cin_i;
    for (int j = 0; j < GROUP; j++) begin
      logic pass;
      logic cj;
      pass = 1'b1;
      cj   = 1'b0;
      for (int k = j; k >= 0; k--) begin
        cj   = cj | (gen_i[k] & pass);
        pass = pass & prop_i[k];
      end
      carry_o[j+1] = cj | (pass & cin_i);
    end
  end
endmodule

// File: rtl/usub_cla_adder.sv
module usub_cla_adder
  import usub_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned GROUP = DEF_GROUP
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int unsigned NGRP = ceil_div(WIDTH, GROUP);
  localparam int unsigned PADW = NGRP * GROUP;

  logic [PADW-1:0] prop;
  logic [PADW-1:0] gen;
  logic [PADW:0]   carry;

  // Per-bit propagate and generate; pad bits beyond WIDTH are inert.
  for (genvar i = 0; i < PADW; i++) begin : g_pg
    if (i < WIDTH) begin : g_live
      assign prop[i] = a_i[i] ^ b_i[i];
      assign gen[i]  = a_i[i] & b_i[i];
    end else begin : g_pad
      assign prop[i] = 1'b0;
      assign gen[i]  = 1'b0;
    end
  end

  assign carry[0] = cin_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GROUP:0] gc;
    usub_lookahead_group #(.GROUP(GROUP)) u_la (
      .prop_i  (prop[g*GROUP +: GROUP]),
      .gen_i   (gen[g*GROUP +: GROUP]),
      .cin_i   (carry[g*GROUP]),
      .carry_o (gc)
    );
    for (genvar j = 1; j <= GROUP; j++) begin : g_c
      assign carry[g*GROUP + j] = gc[j];
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    assign sum_o[i] = prop[i] ^ carry[i];
  end
  assign cout_o = carry[WIDTH];

  // R4 support: lookahead result agrees with plain binary addition.
  always_comb begin
    p_add_exact_r4: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
      else $error("lookahead adder sum mismatch");
  end
endmodule

// File: rtl/usub_complementer.sv
module usub_complementer #(
  parameter int unsigned WIDTH = 7
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic             invert_i,
  output logic [WIDTH-1:0] data_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign data_o[i] = data_i[i] ^ invert_i;
  end
endmodule

// File: rtl/usub_signmag.sv
module usub_signmag
  import usub_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned GROUP = DEF_GROUP
) (
  input  logic [WIDTH-1:0] minuend_i,
  input  logic [WIDTH-1:0] subtrahend_i,
  output logic [WIDTH-1:0] mag_o,
  output logic             neg_o,
  output logic             carry_o
);
  logic [WIDTH-1:0] sub_inv;
  logic [WIDTH-1:0] raw_sum;
  logic             end_carry;
  logic [WIDTH-1:0] fix_in;
  logic             fix_cout;

  // Ones' complement of the subtrahend; the +1 comes in as carry-in.
  usub_complementer #(.WIDTH(WIDTH)) u_sub_inv (
    .data_i   (subtrahend_i),
    .invert_i (1'b1),
    .data_o   (sub_inv)
  );

  usub_cla_adder #(.WIDTH(WIDTH), .GROUP(GROUP)) u_main_add (
    .a_i    (minuend_i),
    .b_i    (sub_inv),
    .cin_i  (1'b1),
    .sum_o  (raw_sum),
    .cout_o (end_carry)
  );

  // Selective re-complement: with no end carry, invert and add one.
  usub_complementer #(.WIDTH(WIDTH)) u_fix_inv (
    .data_i   (raw_sum),
    .invert_i (~end_carry),
    .data_o   (fix_in)
  );

  usub_cla_adder #(.WIDTH(WIDTH), .GROUP(GROUP)) u_fix_add (
    .a_i    (fix_in),
    .b_i    ({WIDTH{1'b0}}),
    .cin_i  (~end_carry),
    .sum_o  (mag_o),
    .cout_o (fix_cout)
  );

  assign carry_o = end_carry;
  assign neg_o   = ~end_carry;

  always_comb begin
    p_pos_diff_r1: assert (!(minuend_i > subtrahend_i) || (mag_o == WIDTH'(minuend_i - subtrahend_i) && !neg_o))
      else $error("positive difference wrong");
    p_neg_diff_r2: assert (!(minuend_i < subtrahend_i) || (mag_o == WIDTH'(subtrahend_i - minuend_i) && neg_o))
      else $error("negative difference wrong");
    p_equal_zero_r3: assert (!(minuend_i == subtrahend_i) || (mag_o == '0 && !neg_o))
      else $error("equal operands not zero");
    p_carry_cmp_r4: assert (carry_o == (minuend_i >= subtrahend_i))
      else $error("end carry disagrees with comparison");
    p_sign_inv_r5: assert (neg_o == !carry_o)
      else $error("sign not inverse of carry");
    p_no_overflow_r8: assert (!fix_cout)
      else $error("magnitude overflowed n bits");
  end
endmodule

// File: tb/usub_signmag_tb.sv
module usub_signmag_tb;
  localparam int unsigned W = 7;
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  // cls: 0 R1, 1 R2, 2 R3, 3 R6, 4 R7, 5 R8
  typedef struct packed {
    logic [W-1:0] m;
    logic [W-1:0] n;
    logic [2:0]   cls;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] m_in = '0;
  logic [W-1:0] n_in = '0;
  logic [W-1:0] mag;
  logic neg, cout;
  int checks = 0;
  int errors = 0;
  item_t q[$];

  always #5 clk = ~clk;

  usub_signmag #(.WIDTH(W)) u_dut (
    .minuend_i    (m_in),
    .subtrahend_i (n_in),
    .mag_o        (mag),
    .neg_o        (neg),
    .carry_o      (cout)
  );

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic drive(input logic [W-1:0] m, input logic [W-1:0] n, input logic [2:0] c);
    item_t it;
    @(posedge clk);
    m_in = m;
    n_in = n;
    it.m = m; it.n = n; it.cls = c;
    q.push_back(it);
  endtask

  task automatic drive_auto(input logic [W-1:0] m, input logic [W-1:0] n);
    logic [2:0] c;
    if (m == n) c = 3'd2;
    else if (n == '0) c = 3'd3;
    else if (m > n) c = 3'd0;
    else c = 3'd1;
    drive(m, n, c);
  endtask

  // Monitor: compares DUT outputs against independently computed values.
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      logic [W-1:0] e_mag;
      logic e_cry;
      it = q.pop_front();
      e_cry = (it.m >= it.n);
      e_mag = e_cry ? W'(it.m - it.n) : W'(it.n - it.m);
      checks++;
      if (mag !== e_mag) begin
        errors++;
        $display("FAIL %s mag m=%0d n=%0d actual=%0d expected=%0d", tag_of(it.cls), it.m, it.n, mag, e_mag);
      end
      checks++;
      if (cout !== e_cry) begin
        errors++;
        $display("FAIL R4 carry m=%0d n=%0d actual=%0b expected=%0b", it.m, it.n, cout, e_cry);
      end
      checks++;
      if (neg !== !e_cry) begin
        errors++;
        $display("FAIL R5 neg m=%0d n=%0d actual=%0b expected=%0b", it.m, it.n, neg, !e_cry);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset state: zero operands, R3
    drive(7'd0, 7'd0, 3'd2);
    // R7 worked example, both orders
    drive(7'b1010100, 7'b1000011, 3'd4);
    drive(7'b1000011, 7'b1010100, 3'd4);
    // R8 extremes
    drive(7'd0, ALL1, 3'd5);
    drive(ALL1, 7'd0, 3'd5);
    drive(ALL1, ALL1, 3'd2);
    // R6 zero subtrahend
    drive(7'd45, 7'd0, 3'd3);
    // Exhaustive sweep covering R1, R2, R3, R6
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        drive_auto(W'(a), W'(b));
      end
    end
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule